// File: doc/BRIEF.md
# Extended Register Tag Manager

This block looks after a physical register file in which every full-width register carries a two-bit side slot: a valid flag and one data bit. The side slot can hold a result of exactly zero or one, so such a result does not need to occupy a full register. The block hands out destination tags from a plain free list of register indices. Each tag is one bit wider than a register index. The extra top bit records whether the new owner also received the side slot (top bit 0) or the register alone (top bit 1). At allocation, that bit is copied from the chosen register's side-slot valid flag.

When a result is written, the block looks at the tag's top bit and the value, and picks the side slot or the register. If an owner of both writes a 0 or 1, the value goes into the side slot and the register returns to the free list straight away, while the destination tag stays the same. A read port decodes any tag into the right value. A release port returns what a retiring tag still holds. Rename tables and scheduling sit outside this block.

Top module: `ert_tag_mgr`

## Requirements
- R1: After reset every register is free, `free_count` equals the register count, `alloc_ok` is high, and the offered tag is index 0 with top bit 0.
- R2: The offered tag always names the lowest-numbered free register. Its top bit equals that register's side-slot valid flag. A granted request (`alloc_req` with `alloc_ok`) removes the register from the free list, so `free_count` drops by one on the next cycle.
- R3: A write with a top-bit-0 tag and a value whose bits above bit 0 are not all zero stores the value in the register and clears the side-slot valid flag. The register stays allocated.
- R4: A write with a top-bit-0 tag and a value of 0 or 1 sets the side-slot valid flag and stores bit 0 in the side-slot data bit. It returns the register to the free list, so `free_count` rises by one on the next cycle.
- R5: A write with a top-bit-1 tag stores the value in the register, even when the value is 0 or 1. It leaves the side slot's flag and data bit unchanged.
- R6: `rd_data` is combinational. For a top-bit-1 tag it is the register. For a top-bit-0 tag whose side slot is valid, it is the data bit zero-extended. For a top-bit-0 tag whose side slot is not valid, it is the register.
- R7: Releasing a top-bit-1 tag, or a top-bit-0 tag whose side slot is not valid, returns the register to the free list.
- R8: Releasing a top-bit-0 tag whose side slot is valid clears the valid flag and leaves `free_count` unchanged.
- R9: A register freed by a side-slot write is offered again from the next cycle with top bit 1. Reads of the earlier top-bit-0 tag still return the side-slot value after the register has been given a new value.
- R10: A request made while no register is free is ignored, and `free_count` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Take the offered tag this cycle |
| alloc_ok | output | 1 | A register is free and a tag is offered |
| alloc_tag | output | IDX_W+1 | Offered tag: {side-slot flag, register index} |
| free_count | output | CNT_W | Number of free registers |
| wr_en | input | 1 | Result write strobe |
| wr_tag | input | IDX_W+1 | Destination tag of the result |
| wr_data | input | DW | Result value |
| rel_en | input | 1 | Release strobe for a retiring tag |
| rel_tag | input | IDX_W+1 | Tag being released |
| rd_tag | input | IDX_W+1 | Tag to read |
| rd_data | output | DW | Decoded value for `rd_tag` |

## Verification
The assertions assume the caller uses the block correctly:
- At most one tag with top bit 0 is live per register.
- Each tag is written at most once and released once.
- A write and a release never target the same tag in the same cycle.

The bench meets these conditions by keeping its own list of live tags and issuing at most one operation per cycle. Writes and releases only ever pick tags from that list. Some checks need to attribute a change in `free_count` to a single cause. Those checks apply only in cycles where the other ports are idle, and the one-operation-per-cycle stimulus provides such cycles throughout the run.

// File: rtl/ert_pkg.sv
`timescale 1ns/1ps
package ert_pkg;
  // decision taken for one result write
  typedef struct packed {
    logic reg_we;    // store value in full-width register
    logic side_set;  // mark side slot valid with bit 0
    logic side_clr;  // mark side slot invalid
    logic give_back; // return register to free list
  } wr_act_t;

  typedef enum logic {SRC_MAIN = 1'b0, SRC_SIDE = 1'b1} rd_src_e;
endpackage

// File: rtl/ert_free_list.sv
`timescale 1ns/1ps
module ert_free_list #(
  parameter int NPREG = 16,
  localparam int IDX_W = $clog2(NPREG),
  localparam int CNT_W = $clog2(NPREG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_en,
  input  logic             ret_a_en,
  input  logic [IDX_W-1:0] ret_a_idx,
  input  logic             ret_b_en,
  input  logic [IDX_W-1:0] ret_b_idx,
  output logic             any_free,
  output logic [IDX_W-1:0] pick_idx,
  output logic [CNT_W-1:0] count
);
  logic [NPREG-1:0] avail_q, avail_d;
  logic             avail_en;

  always_comb begin
    pick_idx = '0;
    for (int i = NPREG - 1; i >= 0; i--) begin
      if (avail_q[i]) pick_idx = IDX_W'(i);
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NPREG; i++) count = count + CNT_W'(avail_q[i]);
  end

  assign any_free = |avail_q;

  always_comb begin
    avail_d = avail_q;
    if (take_en && any_free) avail_d[pick_idx] = 1'b0;
    if (ret_a_en) avail_d[ret_a_idx] = 1'b1;
    if (ret_b_en) avail_d[ret_b_idx] = 1'b1;
  end

  assign avail_en = (take_en && any_free) || ret_a_en || ret_b_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        avail_q <= '1;
    else if (avail_en) avail_q <= avail_d;
  end
endmodule

// File: rtl/ert_side_slots.sv
`timescale 1ns/1ps
module ert_side_slots #(
  parameter int NPREG = 16,
  localparam int IDX_W = $clog2(NPREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_bit,
  input  logic             clr_a_en,
  input  logic [IDX_W-1:0] clr_a_idx,
  input  logic             clr_b_en,
  input  logic [IDX_W-1:0] clr_b_idx,
  output logic [NPREG-1:0] side_v,
  output logic [NPREG-1:0] side_d
);
  logic [NPREG-1:0] v_q, v_d, d_q, d_d;
  logic             upd_en;

  always_comb begin
    v_d = v_q;
    d_d = d_q;
    if (clr_a_en) v_d[clr_a_idx] = 1'b0;
    if (clr_b_en) v_d[clr_b_idx] = 1'b0;
    if (set_en) begin
      v_d[set_idx] = 1'b1;
      d_d[set_idx] = set_bit;
    end
  end

  assign upd_en = set_en || clr_a_en || clr_b_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      d_q <= '0;
    end else if (upd_en) begin
      v_q <= v_d;
      d_q <= d_d;
    end
  end

  assign side_v = v_q;
  assign side_d = d_q;
endmodule

// File: rtl/ert_main_store.sv
`timescale 1ns/1ps
module ert_main_store #(
  parameter int NPREG = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(NPREG)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] cell_q [NPREG];

  for (genvar g = 0; g < NPREG; g++) begin : g_cell
    logic cell_en;
    assign cell_en = we && (widx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (cell_en) cell_q[g] <= wdata;
    end
  end

  assign rdata = cell_q[ridx];
endmodule

// File: rtl/ert_tag_mgr.sv
`timescale 1ns/1ps
module ert_tag_mgr #(
  parameter int NPREG = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(NPREG),
  localparam int TAG_W = IDX_W + 1,
  localparam int CNT_W = $clog2(NPREG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  output logic             alloc_ok,
  output logic [TAG_W-1:0] alloc_tag,
  output logic [CNT_W-1:0] free_count,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [DW-1:0]    wr_data,
  input  logic             rel_en,
  input  logic [TAG_W-1:0] rel_tag,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [DW-1:0]    rd_data
);
  import ert_pkg::*;

  logic [NPREG-1:0] side_v, side_d;
  logic [IDX_W-1:0] pick_idx;
  logic             any_free;
  wr_act_t          wact;
  logic             wr_reg_only, wr_small;
  logic [IDX_W-1:0] wr_idx, rel_idx, rd_idx;
  logic             rel_reg_only, rel_frees, rel_clears;
  rd_src_e          rd_src;
  logic [DW-1:0]    main_rdata;

  // write path decision
  assign wr_reg_only = wr_tag[TAG_W-1];
  assign wr_idx      = wr_tag[IDX_W-1:0];
  assign wr_small    = (wr_data[DW-1:1] == '0);

  always_comb begin
    wact = '0;
    if (wr_en) begin
      if (wr_reg_only) begin
        wact.reg_we = 1'b1;
      end else if (wr_small) begin
        wact.side_set  = 1'b1;
        wact.give_back = 1'b1;
      end else begin
        wact.reg_we   = 1'b1;
        wact.side_clr = 1'b1;
      end
    end
  end

  // release path decision
  assign rel_reg_only = rel_tag[TAG_W-1];
  assign rel_idx      = rel_tag[IDX_W-1:0];
  assign rel_frees    = rel_en && (rel_reg_only || !side_v[rel_idx]);
  assign rel_clears   = rel_en && !rel_reg_only;

  ert_free_list #(.NPREG(NPREG)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_en   (alloc_req),
    .ret_a_en  (wact.give_back),
    .ret_a_idx (wr_idx),
    .ret_b_en  (rel_frees),
    .ret_b_idx (rel_idx),
    .any_free  (any_free),
    .pick_idx  (pick_idx),
    .count     (free_count)
  );

  ert_side_slots #(.NPREG(NPREG)) u_side (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (wact.side_set),
    .set_idx   (wr_idx),
    .set_bit   (wr_data[0]),
    .clr_a_en  (wact.side_clr),
    .clr_a_idx (wr_idx),
    .clr_b_en  (rel_clears),
    .clr_b_idx (rel_idx),
    .side_v    (side_v),
    .side_d    (side_d)
  );

  // read path decode
  assign rd_idx = rd_tag[IDX_W-1:0];
  assign rd_src = (!rd_tag[TAG_W-1] && side_v[rd_idx]) ? SRC_SIDE : SRC_MAIN;

  ert_main_store #(.NPREG(NPREG), .DW(DW)) u_store (
    .clk   (clk),
    .we    (wact.reg_we),
    .widx  (wr_idx),
    .wdata (wr_data),
    .ridx  (rd_idx),
    .rdata (main_rdata)
  );

  assign rd_data   = (rd_src == SRC_SIDE) ? {{(DW-1){1'b0}}, side_d[rd_idx]} : main_rdata;
  assign alloc_ok  = any_free;
  assign alloc_tag = {side_v[pick_idx], pick_idx};
endmodule

// File: rtl/ert_tag_mgr_chk.sv
`timescale 1ns/1ps
module ert_tag_mgr_chk #(
  parameter int NPREG = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(NPREG),
  localparam int TAG_W = IDX_W + 1,
  localparam int CNT_W = $clog2(NPREG + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_req,
  input logic             alloc_ok,
  input logic [CNT_W-1:0] free_count,
  input logic             wr_en,
  input logic [TAG_W-1:0] wr_tag,
  input logic [DW-1:0]    wr_data,
  input logic             rel_en,
  input logic [TAG_W-1:0] rel_tag,
  input logic [NPREG-1:0] side_v,
  input logic [NPREG-1:0] side_d
);
  logic w_low, w_small;
  assign w_low   = wr_en && !wr_tag[TAG_W-1];
  assign w_small = (wr_data[DW-1:1] == '0);

  // R2
  ok_matches_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok == (free_count != '0));

  // R2
  alloc_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && alloc_ok && !wr_en && !rel_en |=>
      free_count == CNT_W'($past(free_count) - 1'b1));

  // R3
  side_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_low && !w_small |=> !side_v[$past(wr_tag[IDX_W-1:0])]);

  // R4
  side_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_low && w_small |=> side_v[$past(wr_tag[IDX_W-1:0])] &&
      (side_d[$past(wr_tag[IDX_W-1:0])] == $past(wr_data[0])));

  // R4
  give_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_low && w_small && !alloc_req && !rel_en |=>
      free_count == CNT_W'($past(free_count) + 1'b1));

  // R5
  side_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_tag[TAG_W-1] && !rel_en |=>
      side_v[$past(wr_tag[IDX_W-1:0])] == $past(side_v[wr_tag[IDX_W-1:0]]) &&
      side_d[$past(wr_tag[IDX_W-1:0])] == $past(side_d[wr_tag[IDX_W-1:0]]));

  // R8
  rel_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en && !rel_tag[TAG_W-1] |=> !side_v[$past(rel_tag[IDX_W-1:0])]);

  // R10
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_count == '0 && !wr_en && !rel_en |=> free_count == '0);
endmodule

bind ert_tag_mgr ert_tag_mgr_chk #(.NPREG(NPREG), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_req  (alloc_req),
  .alloc_ok   (alloc_ok),
  .free_count (free_count),
  .wr_en      (wr_en),
  .wr_tag     (wr_tag),
  .wr_data    (wr_data),
  .rel_en     (rel_en),
  .rel_tag    (rel_tag),
  .side_v     (side_v),
  .side_d     (side_d)
);

// File: tb/test_ert_tag_mgr.sv
`timescale 1ns/1ps
module test_ert_tag_mgr;
  localparam int NPREG = 16;
  localparam int DW    = 32;
  localparam int IDX_W = 4;
  localparam int TAG_W = 5;
  localparam int CNT_W = 5;
  localparam int MAXL  = 64;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             alloc_req, alloc_ok;
  logic [TAG_W-1:0] alloc_tag;
  logic [CNT_W-1:0] free_count;
  logic             wr_en;
  logic [TAG_W-1:0] wr_tag;
  logic [DW-1:0]    wr_data;
  logic             rel_en;
  logic [TAG_W-1:0] rel_tag;
  logic [TAG_W-1:0] rd_tag;
  logic [DW-1:0]    rd_data;

  always #2.5 clk = ~clk;

  ert_tag_mgr #(.NPREG(NPREG), .DW(DW)) i_ert_tag_mgr (.*);

  int total = 0;
  int bad   = 0;

  // bench model
  bit            m_free [NPREG];
  bit            m_v    [NPREG];
  bit            m_d    [NPREG];
  logic [DW-1:0] m_reg  [NPREG];
  logic [TAG_W-1:0] l_tag [MAXL];
  bit               l_wr  [MAXL];
  int               nlive = 0;

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < NPREG; i++) c += int'(m_free[i]);
    return c;
  endfunction

  function automatic int m_pick();
    for (int i = 0; i < NPREG; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  function automatic logic [DW-1:0] m_read(logic [TAG_W-1:0] t);
    int ix = int'(t[IDX_W-1:0]);
    if (!t[TAG_W-1] && m_v[ix]) return {{(DW-1){1'b0}}, m_d[ix]};
    return m_reg[ix];
  endfunction

  function automatic int find_live(logic [TAG_W-1:0] t);
    for (int i = 0; i < nlive; i++) if (l_tag[i] == t) return i;
    return -1;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
    alloc_req = 1'b0;
    wr_en     = 1'b0;
    rel_en    = 1'b0;
  endtask

  task automatic do_alloc(string req, output logic [TAG_W-1:0] got);
    int p = m_pick();
    chk(alloc_ok == (p >= 0), req, "alloc_ok", DW'(alloc_ok), DW'(p >= 0));
    got = alloc_tag;
    if (p >= 0)
      chk(alloc_tag == {m_v[p], IDX_W'(p)}, req, "alloc_tag", DW'(alloc_tag), DW'({m_v[p], IDX_W'(p)}));
    alloc_req = 1'b1;
    tick();
    if (p >= 0) begin
      m_free[p] = 1'b0;
      l_tag[nlive] = {m_v[p], IDX_W'(p)};
      l_wr[nlive]  = 1'b0;
      nlive++;
    end
    chk(int'(free_count) == m_count(), req, "free_count after alloc", DW'(free_count), DW'(m_count()));
  endtask

  task automatic do_write(logic [TAG_W-1:0] t, logic [DW-1:0] d, string req);
    int ix = int'(t[IDX_W-1:0]);
    int li = find_live(t);
    wr_en = 1'b1; wr_tag = t; wr_data = d;
    tick();
    if (t[TAG_W-1]) m_reg[ix] = d;
    else if (d[DW-1:1] == '0) begin
      m_v[ix] = 1'b1; m_d[ix] = d[0]; m_free[ix] = 1'b1;
    end else begin
      m_reg[ix] = d; m_v[ix] = 1'b0;
    end
    if (li >= 0) l_wr[li] = 1'b1;
    chk(int'(free_count) == m_count(), req, "free_count after write", DW'(free_count), DW'(m_count()));
  endtask

  task automatic do_release(logic [TAG_W-1:0] t, string req);
    int ix = int'(t[IDX_W-1:0]);
    int li = find_live(t);
    rel_en = 1'b1; rel_tag = t;
    tick();
    if (t[TAG_W-1] || !m_v[ix]) m_free[ix] = 1'b1;
    if (!t[TAG_W-1]) m_v[ix] = 1'b0;
    if (li >= 0) begin
      l_tag[li] = l_tag[nlive-1];
      l_wr[li]  = l_wr[nlive-1];
      nlive--;
    end
    chk(int'(free_count) == m_count(), req, "free_count after release", DW'(free_count), DW'(m_count()));
  endtask

  task automatic do_read(logic [TAG_W-1:0] t, string req);
    rd_tag = t;
    #1;
    chk(rd_data == m_read(t), req, "rd_data", rd_data, m_read(t));
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [TAG_W-1:0] t, t_old, t_new;
    void'($urandom(32'h00c0ffee));
    rst_n = 1'b0; alloc_req = 1'b0; wr_en = 1'b0; rel_en = 1'b0;
    wr_tag = '0; wr_data = '0; rel_tag = '0; rd_tag = '0;
    for (int i = 0; i < NPREG; i++) begin
      m_free[i] = 1'b1; m_v[i] = 1'b0; m_d[i] = 1'b0; m_reg[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(free_count == CNT_W'(NPREG), "R1", "free_count", DW'(free_count), DW'(NPREG));
    chk(alloc_ok == 1'b1, "R1", "alloc_ok", DW'(alloc_ok), 1);
    chk(alloc_tag == '0, "R1", "alloc_tag", DW'(alloc_tag), 0);

    // R2 fill every register, lowest index first
    for (int i = 0; i < NPREG; i++) do_alloc("R2", t);
    // R10 request while empty
    do_alloc("R10", t);
    chk(free_count == '0, "R10", "free_count when empty", DW'(free_count), 0);

    // R4 side-slot write on tag 0
    t_old = {1'b0, IDX_W'(0)};
    do_write(t_old, 32'd1, "R4");
    do_read(t_old, "R6");
    // R9 freed register offered again with top bit 1
    chk(alloc_tag == {1'b1, IDX_W'(0)}, "R9", "reoffered tag", DW'(alloc_tag), DW'({1'b1, IDX_W'(0)}));
    do_alloc("R9", t_new);
    // R5 register-only write of 0 keeps side slot
    do_write(t_new, 32'd0, "R5");
    do_read(t_old, "R9");
    do_read(t_new, "R5");
    // R3 full value on a top-bit-0 tag
    do_write({1'b0, IDX_W'(1)}, 32'hABCD_1234, "R3");
    do_read({1'b0, IDX_W'(1)}, "R3");
    // R8 release of tag with valid side slot
    do_release(t_old, "R8");
    do_read(t_new, "R8");
    // R7 release of top-bit-0 tag without side slot
    do_release({1'b0, IDX_W'(1)}, "R7");
    // R7 release of top-bit-1 tag
    do_release(t_new, "R7");
    while (nlive > 0) do_release(l_tag[0], "R7");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op = int'($urandom % 4);
      if (op == 0 || nlive == 0) do_alloc("R2", t);
      else if (op == 1) begin
        int li = int'($urandom % 32'(nlive));
        if (!l_wr[li]) begin
          int k = int'($urandom % 3);
          logic [DW-1:0] d = (k == 0) ? 32'd0 : (k == 1) ? 32'd1 : $urandom;
          do_write(l_tag[li], d, l_tag[li][TAG_W-1] ? "R5" : "R4");
        end else do_alloc("R2", t);
      end else if (op == 2) begin
        int li = int'($urandom % 32'(nlive));
        do_release(l_tag[li], "R7");
      end else begin
        int li = int'($urandom % 32'(nlive));
        if (l_wr[li]) do_read(l_tag[li], "R6");
        else do_alloc("R2", t);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule